// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block inspects a received Ethernet frame one byte at a time and raises a wake request when the frame carries a wake-up pattern. The pattern is a synchronisation run of at least six 0xFF bytes, followed directly by sixteen consecutive copies of the station's 48-bit address. The pattern may appear anywhere in the frame and may appear more than once. Address filtering and CRC checking are done by neighbouring logic. Their verdicts arrive with the last byte of the frame, and the wake request is raised only when both are good and waking is enabled.

Bytes arrive on a valid/ready stream. Each byte carries start-of-frame and end-of-frame markers. The block never applies back-pressure: `rx_ready` goes high on the first clock after reset and stays high. A byte is consumed on every clock edge where `rx_valid` and `rx_ready` are both high. Cycles where `rx_valid` is low carry nothing and leave the matcher untouched. The wake request is sticky, and the system side clears it with a pulse on `wake_clr`.

Top module: `mpw_detect`

## Requirements
- R1: A frame matches only if it contains six 0xFF bytes followed immediately by sixteen copies of `station_mac`, sent most significant byte first (`station_mac[47:40]` first). Fewer than six 0xFF bytes, fewer than sixteen copies, or copies in another byte order give no wake.
- R2: More than six 0xFF bytes may come before the first address copy, and the match still succeeds.
- R3: The pattern may start at any byte offset after other payload. An incomplete occurrence does not prevent a later complete one from matching, and a frame with several complete occurrences matches.
- R4: A byte that breaks the address copies sends the matcher back to the search for the 0xFF run, and that same byte is examined as a candidate sync byte. A breaking 0xFF counts as the first byte of a new run.
- R5: The wake request is set only if `addr_ok` is high on the end-of-frame byte. Its value on other bytes has no effect.
- R6: The wake request is set only if `crc_ok` is high on the end-of-frame byte. Its value on other bytes has no effect.
- R7: The wake request is set only if `wake_en` is high on the end-of-frame byte.
- R8: `wake_req` is set on the clock edge that consumes a qualifying end-of-frame byte, and then stays high. A `wake_clr` pulse clears it. If a set and a clear occur in the same cycle, the set wins.
- R9: A start-of-frame byte and an end-of-frame byte each discard all matcher progress. A pattern split across two frames never matches.
- R10: `rx_ready` is high in every cycle after the first clock following reset. Cycles with `rx_valid` low are ignored, even when `rx_data` holds 0xFF, so idle gaps inside a pattern do not break it.
- R11: While reset is active and after it is released, `wake_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_data | input | 8 | Frame byte |
| rx_valid | input | 1 | Byte on `rx_data` is valid |
| rx_ready | output | 1 | Block can accept a byte (always high after reset) |
| rx_sof | input | 1 | Byte is the first byte of a frame |
| rx_eof | input | 1 | Byte is the last byte of a frame |
| addr_ok | input | 1 | Destination address passed filtering; sampled with the last byte |
| crc_ok | input | 1 | Frame CRC is good; sampled with the last byte |
| station_mac | input | 48 | Station address, first wire byte in bits 47:40 |
| wake_en | input | 1 | Wake detection enable |
| wake_clr | input | 1 | Clears the wake request |
| wake_req | output | 1 | Sticky wake request |

## Verification
The assertions assume three things about the inputs. `station_mac` is a unicast address, so its first byte is never 0xFF and it stays constant while frames flow. Every frame opens with a start-of-frame byte and closes with an end-of-frame byte. The qualifier inputs matter only on the end-of-frame beat.

The stimulus uses one fixed unicast address and builds each frame from a byte list in which the first and last bytes carry the markers. On the beats before the last one, the bench drives `addr_ok` and `crc_ok` to the inverse of their final values, so that any early sampling shows up as a wrong result. Some runs insert idle cycles with 0xFF on the data lines while `rx_valid` is low, to test that non-valid cycles are ignored.

// File: rtl/mpw_pkg.sv
package mpw_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_ADDR = 1'b1
  } mstate_t;
endpackage

// File: rtl/mpw_byte_pick.sv
module mpw_byte_pick #(
  parameter int BYTE_W    = 8,
  parameter int MAC_BYTES = 6,
  localparam int MAC_W    = BYTE_W * MAC_BYTES,
  localparam int LANE_W   = (MAC_BYTES > 1) ? $clog2(MAC_BYTES) : 1
) (
  input  logic [MAC_W-1:0]  mac,
  input  logic [LANE_W-1:0] lane,
  output logic [BYTE_W-1:0] pick
);
  logic [BYTE_W-1:0] lane_byte [MAC_BYTES];

  for (genvar gi = 0; gi < MAC_BYTES; gi++) begin : g_lane
    assign lane_byte[gi] = mac[MAC_W-1-gi*BYTE_W -: BYTE_W];
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < MAC_BYTES; i++) begin
      if (lane == LANE_W'(i)) pick = lane_byte[i];
    end
  end
endmodule

// File: rtl/mpw_matcher.sv
module mpw_matcher
  import mpw_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter int          MAC_BYTES = 6,
  parameter int          SYNC_LEN  = 6,
  parameter int          COPIES    = 16,
  parameter logic [7:0]  SYNC_BYTE = 8'hFF,
  localparam int LANE_W = (MAC_BYTES > 1) ? $clog2(MAC_BYTES) : 1,
  localparam int COPY_W = (COPIES > 1) ? $clog2(COPIES) : 1,
  localparam int CNT_W  = $clog2(SYNC_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              sof,
  input  logic              eof,
  input  logic [BYTE_W-1:0] data,
  input  logic [BYTE_W-1:0] exp_byte,
  output logic [LANE_W-1:0] cur_lane,
  output logic [CNT_W-1:0]  ff_cnt,
  output logic              in_addr,
  output logic              found_q,
  output logic              found_next
);
  mstate_t           st_q, b_st, n_st;
  logic [CNT_W-1:0]  cnt_q, b_cnt, n_cnt, hunt_cnt;
  logic [LANE_W-1:0] lane_q, b_lane, n_lane;
  logic [COPY_W-1:0] copy_q, b_copy, n_copy;
  logic              b_found, hit, is_sync, lane_last, copy_last;

  // Frame start wipes progress before the byte itself is examined.
  always_comb begin
    b_st    = sof ? ST_HUNT : st_q;
    b_cnt   = sof ? '0 : cnt_q;
    b_lane  = sof ? '0 : lane_q;
    b_copy  = sof ? '0 : copy_q;
    b_found = sof ? 1'b0 : found_q;
  end

  assign cur_lane  = b_lane;
  assign is_sync   = (data == BYTE_W'(SYNC_BYTE));
  assign lane_last = (b_lane == LANE_W'(MAC_BYTES - 1));
  assign copy_last = (b_copy == COPY_W'(COPIES - 1));

  always_comb begin
    n_st     = b_st;
    n_cnt    = b_cnt;
    n_lane   = b_lane;
    n_copy   = b_copy;
    hit      = 1'b0;
    hunt_cnt = (b_st == ST_ADDR) ? '0 : b_cnt;
    if (b_st == ST_ADDR && data == exp_byte) begin
      if (lane_last) begin
        n_lane = '0;
        if (copy_last) begin
          hit    = 1'b1;
          n_st   = ST_HUNT;
          n_cnt  = '0;
          n_copy = '0;
        end else begin
          n_copy = b_copy + COPY_W'(1);
        end
      end else begin
        n_lane = b_lane + LANE_W'(1);
      end
    end else begin
      // Searching, or a broken copy re-examined from an empty run.
      n_st   = ST_HUNT;
      n_lane = '0;
      n_copy = '0;
      if (is_sync) begin
        n_cnt = (hunt_cnt == CNT_W'(SYNC_LEN)) ? hunt_cnt : hunt_cnt + CNT_W'(1);
      end else if (hunt_cnt == CNT_W'(SYNC_LEN) && data == exp_byte) begin
        n_st   = ST_ADDR;
        n_lane = (MAC_BYTES > 1) ? LANE_W'(1) : '0;
        n_cnt  = '0;
      end else begin
        n_cnt = '0;
      end
    end
  end

  assign found_next = b_found | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_HUNT;
      cnt_q   <= '0;
      lane_q  <= '0;
      copy_q  <= '0;
      found_q <= 1'b0;
    end else if (acc) begin
      if (eof) begin
        st_q    <= ST_HUNT;
        cnt_q   <= '0;
        lane_q  <= '0;
        copy_q  <= '0;
        found_q <= 1'b0;
      end else begin
        st_q    <= n_st;
        cnt_q   <= n_cnt;
        lane_q  <= n_lane;
        copy_q  <= n_copy;
        found_q <= found_next;
      end
    end
  end

  assign ff_cnt  = cnt_q;
  assign in_addr = (st_q == ST_ADDR);
endmodule

// File: rtl/mpw_wake_latch.sv
module mpw_wake_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wake_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wake_o <= 1'b0;
    else if (set_i) wake_o <= 1'b1;
    else if (clr_i) wake_o <= 1'b0;
  end
endmodule

// File: rtl/mpw_detect.sv
module mpw_detect #(
  parameter int         BYTE_W    = 8,
  parameter int         MAC_BYTES = 6,
  parameter int         SYNC_LEN  = 6,
  parameter int         COPIES    = 16,
  parameter logic [7:0] SYNC_BYTE = 8'hFF,
  localparam int MAC_W  = BYTE_W * MAC_BYTES,
  localparam int LANE_W = (MAC_BYTES > 1) ? $clog2(MAC_BYTES) : 1,
  localparam int CNT_W  = $clog2(SYNC_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              addr_ok,
  input  logic              crc_ok,
  input  logic [MAC_W-1:0]  station_mac,
  input  logic              wake_en,
  input  logic              wake_clr,
  output logic              wake_req
);
  logic              ready_q, acc, in_addr, found_q, found_next, wake_set;
  logic [LANE_W-1:0] cur_lane;
  logic [CNT_W-1:0]  ff_cnt;
  logic [BYTE_W-1:0] exp_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign rx_ready = ready_q;
  assign acc      = rx_valid & ready_q;

  mpw_byte_pick #(.BYTE_W(BYTE_W), .MAC_BYTES(MAC_BYTES)) u_pick (
    .mac  (station_mac),
    .lane (cur_lane),
    .pick (exp_byte)
  );

  mpw_matcher #(
    .BYTE_W(BYTE_W), .MAC_BYTES(MAC_BYTES), .SYNC_LEN(SYNC_LEN),
    .COPIES(COPIES), .SYNC_BYTE(SYNC_BYTE)
  ) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .sof        (rx_sof),
    .eof        (rx_eof),
    .data       (rx_data),
    .exp_byte   (exp_byte),
    .cur_lane   (cur_lane),
    .ff_cnt     (ff_cnt),
    .in_addr    (in_addr),
    .found_q    (found_q),
    .found_next (found_next)
  );

  assign wake_set = acc & rx_eof & found_next & addr_ok & crc_ok & wake_en;

  mpw_wake_latch u_wake (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (wake_set),
    .clr_i  (wake_clr),
    .wake_o (wake_req)
  );
endmodule

// File: rtl/mpw_detect_chk.sv
module mpw_detect_chk #(
  parameter int SYNC_LEN = 6,
  parameter int CNT_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             rx_sof,
  input logic             rx_eof,
  input logic             addr_ok,
  input logic             crc_ok,
  input logic             wake_en,
  input logic             wake_clr,
  input logic             wake_req,
  input logic             in_addr,
  input logic [CNT_W-1:0] ff_cnt,
  input logic             found_q
);
  assert_addr_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(rx_valid && rx_ready && rx_eof && addr_ok));

  assert_crc_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(crc_ok));

  assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(wake_en));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !wake_clr) |=> wake_req);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_clr && !(rx_valid && rx_eof)) |=> !wake_req);

  assert_sync_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_addr) |-> ($past(ff_cnt) == CNT_W'(SYNC_LEN)));

  assert_sof_wipe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_sof && !rx_eof) |=> !found_q);

  assert_eof_wipe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_eof) |=> (!found_q && !in_addr));
endmodule

bind mpw_detect mpw_detect_chk #(.SYNC_LEN(SYNC_LEN), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .rx_sof   (rx_sof),
  .rx_eof   (rx_eof),
  .addr_ok  (addr_ok),
  .crc_ok   (crc_ok),
  .wake_en  (wake_en),
  .wake_clr (wake_clr),
  .wake_req (wake_req),
  .in_addr  (in_addr),
  .ff_cnt   (ff_cnt),
  .found_q  (found_q)
);

// File: tb/mpw_detect_tb.sv
`timescale 1ns/1ps
module mpw_detect_tb_top;
  localparam logic [47:0] MAC = 48'h02A1_B2C3_D4E5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic        addr_ok = 1'b0, crc_ok = 1'b0, wake_en = 1'b1, wake_clr = 1'b0;
  logic        rx_ready, wake_req;
  logic [7:0]  fq[$];
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  mpw_detect dut_i (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_sof(rx_sof), .rx_eof(rx_eof), .addr_ok(addr_ok),
    .crc_ok(crc_ok), .station_mac(MAC), .wake_en(wake_en),
    .wake_clr(wake_clr), .wake_req(wake_req)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic add_ff(input int n);
    for (int i = 0; i < n; i++) fq.push_back(8'hFF);
  endtask

  task automatic add_mac(input int copies, input bit reversed);
    for (int c = 0; c < copies; c++)
      for (int b = 0; b < 6; b++)
        fq.push_back(reversed ? MAC[8*b +: 8] : MAC[47-8*b -: 8]);
  endtask

  task automatic add_b(input logic [7:0] v);
    fq.push_back(v);
  endtask

  task automatic send(input logic a_ok, input logic c_ok, input bit gaps, input bit clr_last);
    int last = fq.size() - 1;
    for (int i = 0; i <= last; i++) begin
      if (gaps && (i % 5 == 2)) begin
        @(negedge clk);
        rx_valid = 1'b0; rx_data = 8'hFF; rx_sof = 1'b0; rx_eof = 1'b0;
      end
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fq[i];
      rx_sof   = (i == 0);
      rx_eof   = (i == last);
      addr_ok  = (i == last) ? a_ok : ~a_ok;
      crc_ok   = (i == last) ? c_ok : ~c_ok;
      wake_clr = (i == last) && clr_last;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; wake_clr = 1'b0;
    fq.delete();
  endtask

  task automatic pulse_clr();
    @(negedge clk); wake_clr = 1'b1;
    @(negedge clk); wake_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 wake low after reset", wake_req, 1'b0);
    chk("R10 ready high after reset", rx_ready, 1'b1);
  endtask

  task automatic t_basic();
    pulse_clr();
    add_b(8'h11); add_ff(6); add_mac(16, 0); add_b(8'h22);
    send(1, 1, 0, 0);
    chk("R1 basic pattern wakes", wake_req, 1'b1);
  endtask

  task automatic t_order_and_short();
    pulse_clr();
    add_ff(6); add_mac(16, 1); add_b(8'h00);
    send(1, 1, 0, 0);
    chk("R1 reversed byte order no wake", wake_req, 1'b0);
    add_ff(6); add_mac(15, 0); add_b(8'h00);
    send(1, 1, 0, 0);
    chk("R1 fifteen copies no wake", wake_req, 1'b0);
    add_ff(5); add_mac(16, 0); add_b(8'h00);
    send(1, 1, 0, 0);
    chk("R1 five sync bytes no wake", wake_req, 1'b0);
  endtask

  task automatic t_long_sync();
    pulse_clr();
    add_b(8'h33); add_b(8'h44); add_b(8'h55); add_ff(11); add_mac(16, 0);
    add_b(8'h66); add_b(8'h77);
    send(1, 1, 0, 0);
    chk("R2 eleven sync bytes wake", wake_req, 1'b1);
  endtask

  task automatic t_repeat();
    pulse_clr();
    add_b(8'h01); add_ff(6); add_mac(5, 0); add_b(8'h00);
    add_b(8'h12); add_ff(7); add_mac(16, 0); add_ff(6); add_mac(16, 0); add_b(8'h99);
    send(1, 1, 0, 0);
    chk("R3 broken then complete then repeat", wake_req, 1'b1);
  endtask

  task automatic t_restart();
    pulse_clr();
    add_ff(6); add_b(8'h02); add_b(8'hA1); add_ff(1); add_ff(5); add_mac(16, 0); add_b(8'h00);
    send(1, 1, 0, 0);
    chk("R4 breaking FF counts as first sync", wake_req, 1'b1);
    pulse_clr();
    add_ff(6); add_b(8'h02); add_b(8'hA1); add_ff(1); add_ff(4); add_mac(16, 0); add_b(8'h00);
    send(1, 1, 0, 0);
    chk("R4 breaking FF plus four is short", wake_req, 1'b0);
    add_ff(6); add_mac(3, 0); add_b(8'h02); add_ff(6); add_mac(16, 0); add_b(8'h00);
    send(1, 1, 0, 0);
    chk("R4 mismatch then fresh sync wakes", wake_req, 1'b1);
  endtask

  task automatic t_qualifiers();
    pulse_clr();
    add_ff(6); add_mac(16, 0); add_b(8'h00);
    send(0, 1, 0, 0);
    chk("R5 filter fail no wake", wake_req, 1'b0);
    add_ff(6); add_mac(16, 0); add_b(8'h00);
    send(1, 0, 0, 0);
    chk("R6 crc fail no wake", wake_req, 1'b0);
    wake_en = 1'b0;
    add_ff(6); add_mac(16, 0); add_b(8'h00);
    send(1, 1, 0, 0);
    chk("R7 disabled no wake", wake_req, 1'b0);
    wake_en = 1'b1;
  endtask

  task automatic t_split();
    pulse_clr();
    add_ff(6); add_mac(8, 0);
    send(1, 1, 0, 0);
    chk("R9 first half no wake", wake_req, 1'b0);
    add_mac(8, 0); add_b(8'h00);
    send(1, 1, 0, 0);
    chk("R9 split across frames no wake", wake_req, 1'b0);
  endtask

  task automatic t_gaps();
    pulse_clr();
    add_ff(6); add_mac(16, 0); add_b(8'h00);
    send(1, 1, 1, 0);
    chk("R10 idle gaps ignored", wake_req, 1'b1);
    chk("R10 ready stays high", rx_ready, 1'b1);
  endtask

  task automatic t_sticky();
    pulse_clr();
    chk("R8 clear pulse drops wake", wake_req, 1'b0);
    add_ff(6); add_mac(16, 0); add_b(8'h00);
    send(1, 1, 0, 0);
    add_b(8'h00); add_b(8'h01);
    send(1, 1, 0, 0);
    chk("R8 wake holds across later frame", wake_req, 1'b1);
    pulse_clr();
    chk("R8 clear after hold", wake_req, 1'b0);
    add_ff(6); add_mac(16, 0); add_b(8'h00);
    send(1, 1, 0, 1);
    chk("R8 set wins over same-cycle clear", wake_req, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_order_and_short();
    t_long_sync();
    t_repeat();
    t_restart();
    t_qualifiers();
    t_split();
    t_gaps();
    t_sticky();
    finish_run();
  end
endmodule